// File: doc/BRIEF.md
# Real-Time Clock Alarm Status and Interrupt Controller

This block sits beside the time-keeping counter of a real-time clock. It holds two alarm settings (minute and hour, in BCD), a status byte and an interrupt control byte. On every one-second tick it compares the running time against both alarms. A match sets a sticky flag that the host can only clear and never set. The status byte also reports a power-fail condition and an oscillator-fail condition. It carries the controls for auto-clear on read, oscillator stop and permission to write the time registers.

The host reaches the registers through a plain byte-wide port. An address selects a register and read data returns combinationally. A write-complete strobe applies the write data to the addressed register. A read-complete strobe marks the end of a read, and this is the moment at which clear-on-read takes effect. A separate strobe reports that a write to one of the external time registers has completed.

The block also drives one active-low output pin, presented as a data bit plus an output enable, for an open-drain or tri-state pad. That pin either carries a frequency supplied from outside, signals the alarm-1 interrupt by pulling low, or floats. The interrupt control byte selects which of these it does.

Top module: `rtc_alarm_irq_ctrl`

## Requirements
- R1: The status register (address 4) reads as {bit7 auto-clear enable, bit6 oscillator stop, bit5 always 0, bit4 time-write enable, bit3 oscillator-fail, bit2 alarm-1 flag, bit1 alarm-2 flag, bit0 power-fail}. It resets to 0x01. A status write loads bits 7, 6 and 4, which also appear on `osc_stop_o` and `time_wr_en_o`.
- R2: An alarm flag is set by a match and nothing else. A status write with 0 in the flag's bit clears it. A status write with 1 in that bit leaves it unchanged. When a set and a clear happen in the same cycle, the set wins.
- R3: While auto-clear enable is 1, a read-complete strobe at the status address clears both alarm flags. While it is 0, reads leave the flags alone.
- R4: An alarm whose hour byte has a format bit (bit7, 1 = 24-hour) different from the clock hour's bit7 never matches.
- R5: Power-fail is 1 out of reset. It clears on the first `time_wr_done_i` strobe, and status writes cannot change it.
- R6: A match requires the following, all in the same cycle: `sec_tick_i` high, seconds equal to 0x00, minute equal to the alarm minute, hour equal to the alarm hour, and the alarm's enable bit set. Each matching second therefore sets the flag at most once.
- R7: Oscillator-fail sets in every cycle in which `osc_ok_i` is low. A status write with bit3 = 0 clears it only when `osc_ok_i` is high.
- R8: The interrupt control register (address 5) holds bit6 alarm-1 enable, bit5 alarm-2 enable, bits4:3 frequency select (also on `freq_sel_o`), bit2 pin-function select and bit0 alarm-1 pin enable. Bits 7 and 1 read 0 and ignore writes. It resets to 0x00.
- R9: When pin enable and pin-function select are both 1, the pin is driven low exactly while alarm-1 enable and the alarm-1 flag are both 1. At all other times it floats.
- R10: When pin enable and pin-function select are both 0, the pin is driven with `freq_i`. In the other two combinations it floats.
- R11: The alarm minute registers (addresses 0 and 2) keep bits 6:0. The alarm hour registers (addresses 1 and 3) keep bits 7 and 5:0. Unused bits and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| sec_tick_i | input | 1 | One-cycle pulse per elapsed second |
| cur_sec_i | input | 8 | Current seconds, BCD |
| cur_min_i | input | 8 | Current minutes, BCD |
| cur_hour_i | input | 8 | Current hour, bit7 = 24-hour format |
| osc_ok_i | input | 1 | Oscillation detected |
| freq_i | input | 1 | Divided frequency for the pin |
| time_wr_done_i | input | 1 | A write to a time register completed |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_wr_i | input | 1 | Write-complete strobe |
| reg_rd_done_i | input | 1 | Read-complete strobe |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` |
| pin_o | output | 1 | Pin data value |
| pin_oe_o | output | 1 | Pin drive enable (0 = high impedance) |
| freq_sel_o | output | 2 | Frequency select to the divider |
| osc_stop_o | output | 1 | Oscillator disable |
| time_wr_en_o | output | 1 | Permission to write time registers |

## Verification
The assertions assume that the host never raises the write-complete and read-complete strobes in the same cycle. They also assume that reserved bit 6 of the clock hour stays 0, so that a format mismatch is the only way for hour bytes with equal digits to differ. The stimulus keeps the two bus strobes mutually exclusive and masks every generated clock hour with 0xBF. It steers minutes and hours toward the programmed alarm values, so that both true matches and format-flipped near-matches occur often.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;
  localparam int unsigned DW     = 8;
  localparam int unsigned AW     = 3;
  localparam int unsigned N_ALM  = 2;

  typedef logic [DW-1:0] byte_t;

  // register addresses
  localparam logic [AW-1:0] A_ALM1_MIN = 3'd0;
  localparam logic [AW-1:0] A_ALM1_HR  = 3'd1;
  localparam logic [AW-1:0] A_ALM2_MIN = 3'd2;
  localparam logic [AW-1:0] A_ALM2_HR  = 3'd3;
  localparam logic [AW-1:0] A_STATUS   = 3'd4;
  localparam logic [AW-1:0] A_ICTL     = 3'd5;

  localparam byte_t MIN_MASK  = 8'h7F;
  localparam byte_t HR_MASK   = 8'hBF;
  localparam byte_t ICTL_MASK = 8'h7D;
  localparam int unsigned HR_FMT_BIT = 7;

  // status bit positions
  localparam int unsigned S_ARST = 7;
  localparam int unsigned S_XSTP = 6;
  localparam int unsigned S_WRTE = 4;
  localparam int unsigned S_OSCF = 3;
  localparam int unsigned S_AF1  = 2;
  localparam int unsigned S_AF2  = 1;
  localparam int unsigned S_PWRF = 0;

  // interrupt control bit positions
  localparam int unsigned C_EN1  = 6;
  localparam int unsigned C_EN2  = 5;
  localparam int unsigned C_FSH  = 4;
  localparam int unsigned C_FSL  = 3;
  localparam int unsigned C_PFS  = 2;
  localparam int unsigned C_PEN  = 0;

  typedef enum logic [1:0] {
    PIN_FREQ = 2'b00,
    PIN_HIZ  = 2'b01,
    PIN_OFF  = 2'b10,
    PIN_IRQ  = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_i,
  input  logic  en_i,
  input  byte_t sec_i,
  input  byte_t min_i,
  input  byte_t hour_i,
  input  byte_t alm_min_i,
  input  byte_t alm_hour_i,
  output logic  hit_o
);
  logic min_eq, hour_eq, top_of_min;

  always_comb begin
    min_eq     = ((min_i & MIN_MASK) == alm_min_i);
    hour_eq    = ((hour_i & HR_MASK) == alm_hour_i);
    top_of_min = (sec_i == 8'h00);
    hit_o      = tick_i && en_i && top_of_min && min_eq && hour_eq;
  end

  AST_FMT_MISMATCH_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_hour_i[HR_FMT_BIT] != hour_i[HR_FMT_BIT]) |-> !hit_o); // R4

  AST_HIT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (tick_i && sec_i == 8'h00)); // R6
endmodule

// File: rtl/rtc_status_reg.sv
module rtc_status_reg
  import rtc_alm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             rd_done_i,
  input  byte_t            wdata_i,
  input  logic [N_ALM-1:0] hit_i,
  input  logic             osc_ok_i,
  input  logic             time_wr_done_i,
  output byte_t            stat_o
);
  logic arst_q, xstop_q, wrte_q, oscf_q, pwrf_q;
  logic [N_ALM-1:0] aflag_q;
  logic [N_ALM-1:0] clr_w;
  logic clr_r, osc_clr;

  localparam int unsigned FLAG_POS [N_ALM] = '{S_AF1, S_AF2};

  always_comb begin
    clr_r   = rd_done_i && arst_q;
    osc_clr = wr_i && !wdata_i[S_OSCF] && osc_ok_i;
  end

  for (genvar i = 0; i < N_ALM; i++) begin : g_flag
    assign clr_w[i] = wr_i && !wdata_i[FLAG_POS[i]];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        aflag_q[i] <= 1'b0;
      else if (hit_i[i])
        aflag_q[i] <= 1'b1;
      else if (clr_w[i] || clr_r)
        aflag_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arst_q  <= 1'b0;
      xstop_q <= 1'b0;
      wrte_q  <= 1'b0;
      oscf_q  <= 1'b0;
      pwrf_q  <= 1'b1;
    end else begin
      if (wr_i) begin
        arst_q  <= wdata_i[S_ARST];
        xstop_q <= wdata_i[S_XSTP];
        wrte_q  <= wdata_i[S_WRTE];
      end
      if (!osc_ok_i)
        oscf_q <= 1'b1;
      else if (osc_clr)
        oscf_q <= 1'b0;
      if (time_wr_done_i)
        pwrf_q <= 1'b0;
    end
  end

  always_comb begin
    stat_o         = '0;
    stat_o[S_ARST] = arst_q;
    stat_o[S_XSTP] = xstop_q;
    stat_o[S_WRTE] = wrte_q;
    stat_o[S_OSCF] = oscf_q;
    stat_o[S_AF1]  = aflag_q[0];
    stat_o[S_AF2]  = aflag_q[1];
    stat_o[S_PWRF] = pwrf_q;
  end

  AST_FLAG_SET_ONLY_BY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aflag_q[0]) |-> $past(hit_i[0])); // R2

  AST_AUTO_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done_i && arst_q && hit_i == '0) |=> (aflag_q == '0)); // R3

  AST_PWRF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr_done_i |=> !pwrf_q); // R5

  AST_OSCF_HELD_WITHOUT_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_ok_i |=> oscf_q); // R7

  AST_NO_WR_RD_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && rd_done_i)); // R3
endmodule

// File: rtl/rtc_pin_mux.sv
module rtc_pin_mux
  import rtc_alm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  byte_t ictl_i,
  input  logic  aflag1_i,
  input  logic  freq_i,
  output logic  pin_o,
  output logic  pin_oe_o
);
  pin_mode_e mode;
  logic      irq_act;

  always_comb begin
    mode    = pin_mode_e'({ictl_i[C_PEN], ictl_i[C_PFS]});
    irq_act = ictl_i[C_EN1] && aflag1_i;
    unique case (mode)
      PIN_FREQ: begin pin_o = freq_i; pin_oe_o = 1'b1;    end
      PIN_IRQ:  begin pin_o = 1'b0;   pin_oe_o = irq_act; end
      default:  begin pin_o = 1'b0;   pin_oe_o = 1'b0;    end
    endcase
  end

  AST_IRQ_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe_o && mode != PIN_FREQ) |-> !pin_o); // R9

  AST_HIZ_MODES_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PIN_HIZ || mode == PIN_OFF) |-> !pin_oe_o); // R10
endmodule

// File: rtl/rtc_alarm_irq_ctrl.sv
module rtc_alarm_irq_ctrl
  import rtc_alm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick_i,
  input  logic [7:0] cur_sec_i,
  input  logic [7:0] cur_min_i,
  input  logic [7:0] cur_hour_i,
  input  logic       osc_ok_i,
  input  logic       freq_i,
  input  logic       time_wr_done_i,
  input  logic [2:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  input  logic       reg_wr_i,
  input  logic       reg_rd_done_i,
  output logic [7:0] reg_rdata_o,
  output logic       pin_o,
  output logic       pin_oe_o,
  output logic [1:0] freq_sel_o,
  output logic       osc_stop_o,
  output logic       time_wr_en_o
);
  byte_t alm_min_q  [N_ALM];
  byte_t alm_hour_q [N_ALM];
  byte_t ictl_q, stat;
  logic [N_ALM-1:0] hit;
  logic [N_ALM-1:0] alm_en;

  localparam logic [AW-1:0] MIN_ADDR [N_ALM] = '{A_ALM1_MIN, A_ALM2_MIN};
  localparam logic [AW-1:0] HR_ADDR  [N_ALM] = '{A_ALM1_HR,  A_ALM2_HR};
  localparam int unsigned   EN_POS   [N_ALM] = '{C_EN1, C_EN2};

  for (genvar i = 0; i < N_ALM; i++) begin : g_alm
    assign alm_en[i] = ictl_q[EN_POS[i]];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        alm_min_q[i]  <= '0;
        alm_hour_q[i] <= '0;
      end else if (reg_wr_i) begin
        if (reg_addr_i == MIN_ADDR[i]) alm_min_q[i]  <= reg_wdata_i & MIN_MASK;
        if (reg_addr_i == HR_ADDR[i])  alm_hour_q[i] <= reg_wdata_i & HR_MASK;
      end
    end

    rtc_alarm_match u_match (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (sec_tick_i),
      .en_i       (alm_en[i]),
      .sec_i      (cur_sec_i),
      .min_i      (cur_min_i),
      .hour_i     (cur_hour_i),
      .alm_min_i  (alm_min_q[i]),
      .alm_hour_i (alm_hour_q[i]),
      .hit_o      (hit[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ictl_q <= '0;
    else if (reg_wr_i && reg_addr_i == A_ICTL)
      ictl_q <= reg_wdata_i & ICTL_MASK;
  end

  rtc_status_reg u_stat (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_i           (reg_wr_i && reg_addr_i == A_STATUS),
    .rd_done_i      (reg_rd_done_i && reg_addr_i == A_STATUS),
    .wdata_i        (reg_wdata_i),
    .hit_i          (hit),
    .osc_ok_i       (osc_ok_i),
    .time_wr_done_i (time_wr_done_i),
    .stat_o         (stat)
  );

  rtc_pin_mux u_pin (
    .clk      (clk),
    .rst_n    (rst_n),
    .ictl_i   (ictl_q),
    .aflag1_i (stat[S_AF1]),
    .freq_i   (freq_i),
    .pin_o    (pin_o),
    .pin_oe_o (pin_oe_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      A_ALM1_MIN: reg_rdata_o = alm_min_q[0];
      A_ALM1_HR:  reg_rdata_o = alm_hour_q[0];
      A_ALM2_MIN: reg_rdata_o = alm_min_q[1];
      A_ALM2_HR:  reg_rdata_o = alm_hour_q[1];
      A_STATUS:   reg_rdata_o = stat;
      A_ICTL:     reg_rdata_o = ictl_q;
      default:    reg_rdata_o = '0;
    endcase
    freq_sel_o   = ictl_q[C_FSH:C_FSL];
    osc_stop_o   = stat[S_XSTP];
    time_wr_en_o = stat[S_WRTE];
  end

  AST_ICTL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ictl_q[7] == 1'b0 && ictl_q[1] == 1'b0)); // R8

  AST_STAT_BIT5_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !stat[5]); // R1

  AST_FLAG_HOLDS_WITHOUT_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[S_AF1] && !(reg_addr_i == A_STATUS && (reg_wr_i || reg_rd_done_i)))
      |=> stat[S_AF1]); // R2
endmodule

// File: tb/sim_rtc_alarm_irq_ctrl.sv
module sim_rtc_alarm_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 0, osc_ok = 1, freq = 0, twd = 0;
  logic [7:0] csec = 0, cmin = 0, chour = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic wr = 0, rdd = 0;
  logic [7:0] rdata;
  logic pin, pin_oe, xstop_o, wrte_o;
  logic [1:0] fsel;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  logic [7:0] m_amin [2];
  logic [7:0] m_ahr  [2];
  logic [7:0] m_ictl;
  logic m_arst, m_xstop, m_wrte, m_oscf, m_pwrf;
  logic [1:0] m_af;

  always #5 clk = ~clk;

  rtc_alarm_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sec_tick_i(sec_tick), .cur_sec_i(csec),
    .cur_min_i(cmin), .cur_hour_i(chour), .osc_ok_i(osc_ok), .freq_i(freq),
    .time_wr_done_i(twd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_wr_i(wr), .reg_rd_done_i(rdd), .reg_rdata_o(rdata), .pin_o(pin),
    .pin_oe_o(pin_oe), .freq_sel_o(fsel), .osc_stop_o(xstop_o),
    .time_wr_en_o(wrte_o));

  function automatic logic [7:0] m_stat();
    return {m_arst, m_xstop, 1'b0, m_wrte, m_oscf, m_af[0], m_af[1], m_pwrf};
  endfunction

  function automatic logic m_hit(int i);
    logic en;
    en = (i == 0) ? m_ictl[6] : m_ictl[5];
    return sec_tick && en && csec == 8'h00 && (cmin & 8'h7F) == m_amin[i]
           && (chour & 8'hBF) == m_ahr[i];
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic m_reset();
    for (int i = 0; i < 2; i++) begin m_amin[i] = 0; m_ahr[i] = 0; end
    m_ictl = 0; m_arst = 0; m_xstop = 0; m_wrte = 0; m_oscf = 0; m_pwrf = 1;
    m_af = 0;
  endtask

  // one clock: model updates from inputs held since the last negedge
  task automatic step();
    logic [1:0] h;
    logic swr, srd;
    @(posedge clk);
    h   = {m_hit(1), m_hit(0)};
    swr = wr && addr == 3'd4;
    srd = rdd && addr == 3'd4;
    for (int i = 0; i < 2; i++) begin
      logic wb;
      wb = (i == 0) ? wdata[2] : wdata[1];
      if (h[i]) m_af[i] = 1'b1;
      else if ((swr && !wb) || (srd && m_arst)) m_af[i] = 1'b0;
    end
    if (!osc_ok) m_oscf = 1'b1;
    else if (swr && !wdata[3]) m_oscf = 1'b0;
    if (twd) m_pwrf = 1'b0;
    if (swr) begin m_arst = wdata[7]; m_xstop = wdata[6]; m_wrte = wdata[4]; end
    if (wr) begin
      case (addr)
        3'd0: m_amin[0] = wdata & 8'h7F;
        3'd1: m_ahr[0]  = wdata & 8'hBF;
        3'd2: m_amin[1] = wdata & 8'h7F;
        3'd3: m_ahr[1]  = wdata & 8'hBF;
        3'd5: m_ictl    = wdata & 8'h7D;
        default: ;
      endcase
    end
    @(negedge clk);
    wr = 0; rdd = 0; twd = 0; sec_tick = 0;
  endtask

  task automatic peek(logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic bus_wr(logic [2:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1; step();
  endtask

  task automatic check_all();
    logic [7:0] d;
    logic exp_oe, exp_o;
    peek(3'd4, d);
    chk("R1 status byte", d, m_stat());
    chk("R2 alarm1 flag", {7'd0, d[2]}, {7'd0, m_af[0]});
    chk("R2 alarm2 flag", {7'd0, d[1]}, {7'd0, m_af[1]});
    chk("R5 power-fail", {7'd0, d[0]}, {7'd0, m_pwrf});
    chk("R7 osc-fail", {7'd0, d[3]}, {7'd0, m_oscf});
    peek(3'd5, d);
    chk("R8 int control", d, m_ictl);
    chk("R8 freq select", {6'd0, fsel}, {6'd0, m_ictl[4:3]});
    chk("R1 ctl outputs", {6'd0, xstop_o, wrte_o}, {6'd0, m_xstop, m_wrte});
    case ({m_ictl[0], m_ictl[2]})
      2'b00:   begin exp_oe = 1; exp_o = freq; end
      2'b11:   begin exp_oe = m_ictl[6] & m_af[0]; exp_o = 0; end
      default: begin exp_oe = 0; exp_o = 0; end
    endcase
    if (m_ictl[0] & m_ictl[2]) begin
      chk("R9 pin oe", {7'd0, pin_oe}, {7'd0, exp_oe});
      if (exp_oe) chk("R9 pin level", {7'd0, pin}, 8'd0);
    end else begin
      chk("R10 pin oe", {7'd0, pin_oe}, {7'd0, exp_oe});
      if (exp_oe) chk("R10 pin level", {7'd0, pin}, {7'd0, exp_o});
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1977));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    check_all();
    for (int a = 0; a < 4; a++) begin
      peek(a[2:0], d); chk("R11 alarm reg reset", d, 8'h00);
    end
    // reserved bits and masks
    bus_wr(3'd5, 8'hFF); check_all();
    bus_wr(3'd1, 8'hFF); peek(3'd1, d); chk("R11 hour mask", d, 8'hBF);
    bus_wr(3'd0, 8'hFF); peek(3'd0, d); chk("R11 minute mask", d, 8'h7F);
    peek(3'd6, d); chk("R11 unmapped read", d, 8'h00);
    // alarm1 = 24h 08:30
    bus_wr(3'd0, 8'h30); bus_wr(3'd1, 8'h88); bus_wr(3'd5, 8'h45);
    // format mismatch: clock 12h 08:30
    cmin = 8'h30; chour = 8'h08; csec = 8'h00; sec_tick = 1; step();
    check_all(); chk("R4 mismatch no flag", {7'd0, m_af[0]}, 8'd0);
    // off-second tick
    chour = 8'h88; csec = 8'h01; sec_tick = 1; step();
    check_all(); chk("R6 no match off second", {7'd0, m_af[0]}, 8'd0);
    // no tick
    csec = 8'h00; sec_tick = 0; step();
    check_all(); chk("R6 no match without tick", {7'd0, m_af[0]}, 8'd0);
    sec_tick = 1; step();
    check_all(); chk("R2 match sets flag", {7'd0, m_af[0]}, 8'd1);
    chk("R9 pin asserted", {6'd0, pin_oe, pin}, 8'h02);
    // write 1 keeps, write 0 clears
    bus_wr(3'd4, 8'h06); check_all();
    bus_wr(3'd4, 8'h80); check_all();
    chk("R2 write 0 clears", {7'd0, m_af[0]}, 8'd0);
    // clear-on-read
    sec_tick = 1; step();
    addr = 3'd4; rdd = 1; step(); check_all();
    chk("R3 clear on read", {7'd0, m_af[0]}, 8'd0);
    // power-fail and osc fail
    twd = 1; step(); check_all();
    osc_ok = 0; step(); osc_ok = 1; check_all();
    osc_ok = 0; bus_wr(3'd4, 8'h00); check_all();
    chk("R7 no clear while stopped", {7'd0, m_oscf}, 8'd1);
    osc_ok = 1; bus_wr(3'd4, 8'h00); check_all();

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int k, op;
      k = $urandom % 2;
      case ($urandom % 4)
        0: cmin = $urandom;
        default: cmin = m_amin[k];
      endcase
      case ($urandom % 4)
        0: chour = $urandom & 8'hBF;
        1: chour = m_ahr[k] ^ 8'h80;
        default: chour = m_ahr[k];
      endcase
      csec = ($urandom % 2) ? 8'h00 : 8'h01 + 8'($urandom % 89);
      sec_tick = ($urandom % 3) == 0;
      osc_ok = ($urandom % 10) != 0;
      twd = ($urandom % 25) == 0;
      freq = $urandom;
      op = $urandom % 8;
      case (op)
        0: begin addr = 3'd4; wdata = $urandom; wr = 1; end
        1: begin addr = 3'd5; wdata = $urandom; wr = 1; end
        2, 3: begin addr = 3'd4; rdd = 1; end
        4: begin addr = 3'($urandom % 4); wdata = $urandom; wr = 1; end
        5: begin addr = 3'($urandom % 8); rdd = 1; end
        default: ;
      endcase
      step();
      check_all();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule